// File: doc/BRIEF.md
# Debug Halt Request Unit

This unit decides when a processor must stop for a debug session. A write-only control register, reached through a simple write strobe at control address 0x10, holds four comparator enables and a halt flag. The flag serves both as a "stop at the next instruction" command and as the latch that keeps the processor halted. Four address comparators watch the fetch address. They act only on a fetch cycle that carries the first opcode byte of an instruction. Any enabled match raises the halt request in that same cycle and sets the flag.

The flag is the state of a two-state machine. In ST_RUN the processor executes. In ST_HALT the halt request is held high and the processor must not advance. There are three transitions:

- RUN_TO_HALT is taken on an enabled match or on a write of 1 to the flag.
- HALT_TO_RUN is taken on a write of 0 to the flag in a cycle with no match.
- HALT_STAY covers every other cycle in ST_HALT, including a clear that coincides with a match.

During reset the machine loads ST_HALT if the debug clock pin is high and the debug data pin is low at the last reset edge. Otherwise it loads ST_RUN. The first instruction after reset then breaks.

Top module: `dbg_halt_unit`

## Requirements
- R1: At the final clock edge with reset low, all comparator enables clear to 0. If the pin pair is not (debug clock pin = 1, debug data pin = 0), halt_req is 0 after reset and no fetch raises it.
- R2: If the debug clock pin is 1 and the debug data pin is 0 at the final reset edge, halt_req is 1 from the first cycle after reset. It stays 1 until the flag is cleared by a write.
- R3: A control write takes effect only when cfg_wr is 1 and cfg_addr equals 0x10. A write to any other address changes neither the flag nor the enables.
- R4: A control write with bit 7 = 1 makes halt_req 1 from the cycle after the write edge.
- R5: A control write with bit 7 = 0 in a cycle with no enabled match makes halt_req 0 from the next cycle. This holds provided no new match occurs in that cycle.
- R6: Bits 3, 4, 5 and 6 enable comparators 0, 1, 2 and 3. An enabled comparator whose 24-bit reference equals fetch_addr while fetch_first is 1 drives halt_req to 1 in that same cycle. halt_req then stays 1 until a later clear.
- R7: No match occurs when fetch_first is 0, when the comparator's enable is 0, or when the address differs in any bit.
- R8: If a clear write and an enabled match fall in the same cycle, the match wins and halt_req stays 1.
- R9: Bits 2 to 0 of a control write have no effect on the halt behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_clk_pin | input | 1 | Debug clock pin, sampled at reset |
| dbg_dat_pin | input | 1 | Debug data pin, sampled at reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_addr | input | 8 | Control write address |
| cfg_wdata | input | 8 | Control write data |
| fetch_first | input | 1 | Current fetch is the first opcode byte of an instruction |
| fetch_addr | input | 24 | Current fetch address |
| cmp_addrs | input | 96 | Comparator references; comparator i uses bits [24*i+23:24*i] |
| halt_req | output | 1 | Halt request to the processor |

## Verification
The hardest case to reach from the ports is the race in which a clear write and an enabled first-byte match land in the same cycle. The bench must first enable a comparator and then take a break on it. Only then can it present the clear together with another fetch of the matching address. A directed sequence builds this case explicitly. The random phase also draws fetch addresses mostly from the comparator references and mixes frequent writes to the control address, so coincidences of writes, matches and qualifier changes recur many times.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
    localparam int CTL_W    = 8;
    localparam int EN_LSB   = 3;
    localparam int FLAG_BIT = 7;
    localparam int NCMP     = FLAG_BIT - EN_LSB;
    localparam int RSV_W    = EN_LSB;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } halt_state_e;
endpackage

// File: rtl/dbg_halt_cfg.sv
module dbg_halt_cfg
    import dbg_halt_pkg::*;
#(
    parameter int          CADDR_W  = 8,
    parameter logic [7:0]  REG_ADDR = 8'h10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [CADDR_W-1:0] cfg_addr,
    input  logic [CTL_W-1:0]   cfg_wdata,
    output logic               wr_set,
    output logic               wr_clr,
    output logic [NCMP-1:0]    en_q
);
    logic               sel;
    logic [RSV_W-1:0]   rsv_unused;

    assign sel        = cfg_wr && (cfg_addr == CADDR_W'(REG_ADDR));
    assign wr_set     = sel &&  cfg_wdata[FLAG_BIT];
    assign wr_clr     = sel && !cfg_wdata[FLAG_BIT];
    assign rsv_unused = cfg_wdata[RSV_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (sel) begin
            en_q <= cfg_wdata[EN_LSB +: NCMP];
        end
    end
endmodule

// File: rtl/dbg_addr_cmp.sv
module dbg_addr_cmp #(
    parameter int AW = 24
) (
    input  logic          en,
    input  logic          fetch_first,
    input  logic [AW-1:0] fetch_addr,
    input  logic [AW-1:0] ref_addr,
    output logic          hit
);
    assign hit = en && fetch_first && (fetch_addr == ref_addr);
endmodule

// File: rtl/dbg_halt_unit.sv
module dbg_halt_unit
    import dbg_halt_pkg::*;
#(
    parameter int          AW       = 24,
    parameter int          CADDR_W  = 8,
    parameter logic [7:0]  REG_ADDR = 8'h10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dbg_clk_pin,
    input  logic               dbg_dat_pin,
    input  logic               cfg_wr,
    input  logic [CADDR_W-1:0] cfg_addr,
    input  logic [CTL_W-1:0]   cfg_wdata,
    input  logic               fetch_first,
    input  logic [AW-1:0]      fetch_addr,
    input  logic [NCMP*AW-1:0] cmp_addrs,
    output logic               halt_req
);
    halt_state_e     state_q;
    halt_state_e     state_d;
    logic            wr_set;
    logic            wr_clr;
    logic [NCMP-1:0] en_q;
    logic [NCMP-1:0] hit_vec;
    logic            hit_any;
    logic            halted;
    logic            boot_break;

    dbg_halt_cfg #(
        .CADDR_W  (CADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .wr_set    (wr_set),
        .wr_clr    (wr_clr),
        .en_q      (en_q)
    );

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        dbg_addr_cmp #(.AW(AW)) u_cmp (
            .en          (en_q[i]),
            .fetch_first (fetch_first),
            .fetch_addr  (fetch_addr),
            .ref_addr    (cmp_addrs[i*AW +: AW]),
            .hit         (hit_vec[i])
        );
    end

    assign hit_any    = |hit_vec;
    assign boot_break = dbg_clk_pin && !dbg_dat_pin;
    assign halted     = (state_q == ST_HALT);

    // State register: reset loads the boot break decision from the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= boot_break ? ST_HALT : ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions RUN_TO_HALT, HALT_TO_RUN, HALT_STAY.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (hit_any || wr_set) begin
                    state_d = ST_HALT;
                end
            end
            ST_HALT: begin
                if (wr_clr && !hit_any) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // Output: halt at the matching boundary and for as long as halted.
    always_comb begin
        unique case (state_q)
            ST_RUN:  halt_req = hit_any;
            ST_HALT: halt_req = 1'b1;
            default: halt_req = 1'b1;
        endcase
    end
endmodule

// File: rtl/dbg_halt_unit_chk.sv
module dbg_halt_unit_chk
    import dbg_halt_pkg::*;
#(
    parameter int          CADDR_W  = 8,
    parameter logic [7:0]  REG_ADDR = 8'h10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_wr,
    input logic [CADDR_W-1:0] cfg_addr,
    input logic [CTL_W-1:0]   cfg_wdata,
    input logic               fetch_first,
    input logic               hit_any,
    input logic               halted,
    input logic               halt_req
);
    logic sel;
    assign sel = cfg_wr && (cfg_addr == CADDR_W'(REG_ADDR));

    a_r6_match_halts: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |-> halt_req);

    a_r8_match_latches: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |=> halted);

    a_r4_force_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cfg_wdata[FLAG_BIT]) |=> halted);

    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !cfg_wdata[FLAG_BIT] && !hit_any) |=> !halted);

    a_r3_no_stray_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && !hit_any && !sel) |=> !halted);

    a_r7_needs_qualifier: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_first |-> !hit_any);
endmodule

bind dbg_halt_unit dbg_halt_unit_chk #(
    .CADDR_W  (CADDR_W),
    .REG_ADDR (REG_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .fetch_first (fetch_first),
    .hit_any     (hit_any),
    .halted      (halted),
    .halt_req    (halt_req)
);

// File: tb/tb_dbg_halt_unit.sv
module tb_dbg_halt_unit;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 24;
    localparam int NCMP = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            dbg_clk_pin, dbg_dat_pin;
    logic            cfg_wr;
    logic [7:0]      cfg_addr, cfg_wdata;
    logic            fetch_first;
    logic [AW-1:0]   fetch_addr;
    logic [NCMP*AW-1:0] cmp_addrs;
    logic            halt_req;

    logic            exp_flag;
    logic [NCMP-1:0] exp_en;
    int              n_cmp = 0;
    int              n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_halt_unit dut (
        .clk(clk), .rst_n(rst_n), .dbg_clk_pin(dbg_clk_pin), .dbg_dat_pin(dbg_dat_pin),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .fetch_first(fetch_first), .fetch_addr(fetch_addr),
        .cmp_addrs(cmp_addrs), .halt_req(halt_req)
    );

    function automatic logic ref_hit(input logic [NCMP-1:0] en, input logic ff,
                                     input logic [AW-1:0] fa, input logic [NCMP*AW-1:0] refs);
        logic h = 1'b0;
        for (int i = 0; i < NCMP; i++)
            if (en[i] && ff && fa == refs[i*AW +: AW]) h = 1'b1;
        return h;
    endfunction

    function automatic logic [AW-1:0] ref_of(input int i);
        return cmp_addrs[i*AW +: AW];
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: halt_req=%0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic cycle(input logic wr, input logic [7:0] a, input logic [7:0] d,
                         input logic ff, input logic [AW-1:0] fa, input string tag);
        logic h;
        @(negedge clk);
        cfg_wr = wr; cfg_addr = a; cfg_wdata = d; fetch_first = ff; fetch_addr = fa;
        #1;
        h = ref_hit(exp_en, ff, fa, cmp_addrs);
        check(halt_req, exp_flag | h, tag);
        @(posedge clk);
        if (h) exp_flag = 1'b1;
        else if (wr && a == 8'h10) exp_flag = d[7];
        if (wr && a == 8'h10) exp_en = d[6:3];
    endtask

    task automatic idle(input string tag);
        cycle(1'b0, 8'h00, 8'h00, 1'b0, 24'h0, tag);
    endtask

    task automatic do_reset(input logic pc, input logic pd, input string tag);
        @(negedge clk);
        rst_n = 1'b0; cfg_wr = 1'b0; fetch_first = 1'b0;
        dbg_clk_pin = pc; dbg_dat_pin = pd;
        repeat (3) @(posedge clk);
        exp_flag = pc & ~pd;
        exp_en = '0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(halt_req, exp_flag, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: halt_req=%0b expected run to finish", halt_req);
        summary();
        $finish;
    end

    initial begin
        cmp_addrs = {24'hC0FFEE, 24'h00ABCD, 24'h123456, 24'hFFFFFF};
        cfg_wr = 0; cfg_addr = 0; cfg_wdata = 0; fetch_first = 0; fetch_addr = 0;
        dbg_clk_pin = 0; dbg_dat_pin = 1;
        exp_flag = 0; exp_en = 0;

        do_reset(1'b0, 1'b1, "R1 reset state");
        cycle(0, 8'h00, 8'h00, 1, ref_of(0), "R1 no enable after reset");
        cycle(1, 8'h11, 8'hFF, 0, 24'h0, "R3 stray address write");
        cycle(0, 8'h00, 8'h00, 1, ref_of(2), "R3 stray write ignored");
        cycle(0, 8'h10, 8'hFF, 0, 24'h0, "R3 strobe low");
        cycle(0, 8'h00, 8'h00, 1, ref_of(3), "R3 strobe low ignored");
        cycle(1, 8'h10, 8'h07, 0, 24'h0, "R9 low bits write");
        cycle(0, 8'h00, 8'h00, 1, ref_of(1), "R9 low bits no effect");
        cycle(1, 8'h10, 8'h80, 0, 24'h0, "R4 force write");
        idle("R4 forced halt");
        idle("R4 halt held");
        cycle(1, 8'h10, 8'h00, 0, 24'h0, "R5 clear write");
        idle("R5 released");
        cycle(1, 8'h10, 8'h20, 0, 24'h0, "R6 enable comparator 2");
        cycle(0, 8'h00, 8'h00, 0, ref_of(2), "R7 qualifier low");
        cycle(0, 8'h00, 8'h00, 1, ref_of(1), "R7 comparator disabled");
        cycle(0, 8'h00, 8'h00, 1, ref_of(2) ^ 24'h000001, "R7 address differs");
        cycle(0, 8'h00, 8'h00, 1, ref_of(2), "R6 match same cycle");
        idle("R6 halt held after match");
        cycle(1, 8'h10, 8'h20, 1, ref_of(2), "R8 clear with match");
        idle("R8 match wins");
        cycle(1, 8'h10, 8'h20, 0, 24'h0, "R5 clear no match");
        idle("R5 released again");

        do_reset(1'b1, 1'b1, "R1 pins high/high");
        do_reset(1'b1, 1'b0, "R2 boot break");
        idle("R2 boot halt held");
        cycle(1, 8'h10, 8'h00, 0, 24'h0, "R2 boot clear");
        idle("R2 boot released");

        void'($urandom(32'h5EED_1234));
        for (int k = 0; k < 400; k++) begin
            logic wr = ($urandom % 4) == 0;
            logic [7:0] a = (($urandom % 4) != 0) ? 8'h10 : 8'($urandom);
            logic [7:0] d = 8'($urandom);
            logic ff = $urandom % 2;
            logic [AW-1:0] fa = (($urandom % 4) != 0) ? ref_of(int'($urandom % NCMP))
                                                      : AW'($urandom);
            cycle(wr, a, d, ff, fa, "R6/R7/R8 random");
        end

        summary();
        $finish;
    end
endmodule